// File: doc/BRIEF.md
# Cascaded Peripheral Interrupt Aggregator

This block is a secondary interrupt controller. It gathers thirty-two peripheral request lines into one pending-status word and qualifies them with a mask word of the same width. The masked requests are then reduced into three group request lines that feed a primary controller. The audio group takes sources 0 to 7. The miscellaneous group takes sources 8 to 15: clock, keyboard, pointer and timers. The super-I/O group takes sources 16 to 31: the parallel port and two serial ports with their DMA events.

Most sources are level requests. Their status bit follows the line. Three sources are edge requests, at bit positions 16, 22 and 28. A rising edge on one of these lines latches its status bit. Software acknowledges that bit by writing the status word with the bit at zero. Writing a one leaves the bit as it is.

Software loads the mask through a write strobe. Both words can be read at any time. The mask gates only the group lines. The status word always shows the unmasked pending state.

Each edge source runs a two-state capture machine:
- CAP_IDLE goes to CAP_HELD on a rising edge (transition "capture").
- CAP_HELD goes back to CAP_IDLE on a clearing write when no new edge arrives in that cycle (transition "acknowledge").
- Every other case keeps the current state (transition "hold").

Top module: `irq_aggregator`

## Requirements
- R1: While reset is asserted, the status word, the mask word and all three group lines read zero. Sources are low when reset is released.
- R2: When the mask write strobe is high at a clock edge, the mask output shows the write data from that edge onward.
- R3: For each level source (every bit except 16, 22 and 28), the status bit equals the source line sampled at the previous clock edge. Status writes have no effect on it.
- R4: A status bit at position 16, 22 or 28 becomes 1 after the edge at which its line is 1 and was 0 at the edge before. It then stays 1 after the line falls, and while the line stays high, until it is acknowledged.
- R5: A status write with data bit 16, 22 or 28 at 0 clears that latched bit at the write edge. A data bit of 1 leaves the bit unchanged.
- R6: When a rising edge and a clearing write for the same edge bit occur at the same clock edge, the bit stays set.
- R7: The audio group line is the OR of status AND mask over bits 0 to 7.
- R8: The miscellaneous group line is the OR of status AND mask over bits 8 to 15.
- R9: The super-I/O group line is the OR of status AND mask over bits 16 to 31.
- R10: The mask does not alter the status word. A masked source still shows as pending in the status output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 32 | Peripheral request lines, one per source |
| wr_mask_en | input | 1 | Load the mask word from wr_data |
| wr_stat_en | input | 1 | Write the status word from wr_data; a 0 acknowledges an edge bit |
| wr_data | input | 32 | Write data for either word |
| rd_status | output | 32 | Pending status, unmasked |
| rd_mask | output | 32 | Current mask word |
| grp_audio | output | 1 | Audio group request |
| grp_misc | output | 1 | Miscellaneous group request |
| grp_sio | output | 1 | Super-I/O group request |

## Verification
The assertions assume that the source lines and write controls are stable around the rising clock edge. They also assume that the edge sources are low while reset is released, so that no edge is seen across reset. The bench changes every input only on the falling clock edge and holds all sources low through reset. The random phase raises and drops edge sources freely, and sometimes issues a clearing write in the same cycle as an edge, to exercise the capture, acknowledge and hold transitions.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    typedef enum logic {
        CAP_IDLE = 1'b0,
        CAP_HELD = 1'b1
    } cap_state_e;

    localparam int unsigned GRP_COUNT = 3;

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_agg_pkg::*;
#(
    parameter bit IS_EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic clr_req,
    output logic stat
);

    generate
        if (IS_EDGE) begin : g_edge
            cap_state_e state_q;
            cap_state_e state_d;
            logic       prev_q;
            logic       rise;

            assign rise = src & ~prev_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    state_q <= CAP_IDLE;
                    prev_q  <= 1'b0;
                end else begin
                    state_q <= state_d;
                    prev_q  <= src;
                end
            end

            always_comb begin
                state_d = state_q;
                unique case (state_q)
                    CAP_IDLE: if (rise) state_d = CAP_HELD;
                    CAP_HELD: if (clr_req && !rise) state_d = CAP_IDLE;
                    default:  state_d = CAP_IDLE;
                endcase
            end

            assign stat = (state_q == CAP_HELD);
        end else begin : g_level
            logic lvl_q;

            always_ff @(posedge clk) begin
                if (!rst_n) lvl_q <= 1'b0;
                else        lvl_q <= src;
            end

            assign stat = lvl_q;
        end
    endgenerate

endmodule

// File: rtl/irq_grp_reduce.sv
module irq_grp_reduce #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned LO    = 0,
    parameter int unsigned HI    = 7
) (
    input  logic [WIDTH-1:0] stat,
    input  logic [WIDTH-1:0] mask,
    output logic             req
);

    localparam int unsigned SPAN = HI - LO + 1;

    logic [SPAN-1:0] qual;

    assign qual = stat[HI:LO] & mask[HI:LO];
    assign req  = |qual;

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
    parameter int unsigned NUM_SRC  = 32,
    parameter logic [31:0] EDGE_SEL = 32'h1041_0000,
    parameter int unsigned AUD_LO   = 0,
    parameter int unsigned AUD_HI   = 7,
    parameter int unsigned MISC_LO  = 8,
    parameter int unsigned MISC_HI  = 15,
    parameter int unsigned SIO_LO   = 16,
    parameter int unsigned SIO_HI   = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               wr_mask_en,
    input  logic               wr_stat_en,
    input  logic [NUM_SRC-1:0] wr_data,
    output logic [NUM_SRC-1:0] rd_status,
    output logic [NUM_SRC-1:0] rd_mask,
    output logic               grp_audio,
    output logic               grp_misc,
    output logic               grp_sio
);

    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] stat_w;
    logic [NUM_SRC-1:0] clr_w;

    assign clr_w = {NUM_SRC{wr_stat_en}} & ~wr_data;

    always_ff @(posedge clk) begin
        if (!rst_n)          mask_q <= '0;
        else if (wr_mask_en) mask_q <= wr_data;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        irq_src_cell #(
            .IS_EDGE (EDGE_SEL[i])
        ) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .src     (src_in[i]),
            .clr_req (clr_w[i]),
            .stat    (stat_w[i])
        );
    end

    irq_grp_reduce #(.WIDTH(NUM_SRC), .LO(AUD_LO), .HI(AUD_HI)) u_aud (
        .stat (stat_w), .mask (mask_q), .req (grp_audio)
    );

    irq_grp_reduce #(.WIDTH(NUM_SRC), .LO(MISC_LO), .HI(MISC_HI)) u_misc (
        .stat (stat_w), .mask (mask_q), .req (grp_misc)
    );

    irq_grp_reduce #(.WIDTH(NUM_SRC), .LO(SIO_LO), .HI(SIO_HI)) u_sio (
        .stat (stat_w), .mask (mask_q), .req (grp_sio)
    );

    assign rd_status = stat_w;
    assign rd_mask   = mask_q;

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
    parameter int unsigned NUM_SRC  = 32,
    parameter logic [31:0] EDGE_SEL = 32'h1041_0000,
    parameter int unsigned AUD_LO   = 0,
    parameter int unsigned AUD_HI   = 7,
    parameter int unsigned MISC_LO  = 8,
    parameter int unsigned MISC_HI  = 15
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_in,
    input logic               wr_mask_en,
    input logic               wr_stat_en,
    input logic [NUM_SRC-1:0] wr_data,
    input logic [NUM_SRC-1:0] rd_status,
    input logic [NUM_SRC-1:0] rd_mask,
    input logic               grp_audio,
    input logic               grp_misc
);

    logic               seen;
    logic [NUM_SRC-1:0] prev_c;
    logic [NUM_SRC-1:0] edge_m;

    assign edge_m = EDGE_SEL[NUM_SRC-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen   <= 1'b0;
            prev_c <= '0;
        end else begin
            seen   <= 1'b1;
            prev_c <= src_in;
        end
    end

    // R1
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (rd_status == '0 && rd_mask == '0));

    // R2
    p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        $past(wr_mask_en) |-> (rd_mask == $past(wr_data)));

    // R3
    p_level_track_r3: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (rd_status & ~edge_m) == ($past(src_in) & ~edge_m));

    // R4 and R6: an edge always leaves its bit set
    p_edge_set_r6: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (rd_status & $past(src_in & ~prev_c & edge_m)) == $past(src_in & ~prev_c & edge_m));

    // R4: a latched bit survives unless acknowledged
    p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        $past(!wr_stat_en) |-> ((rd_status & $past(rd_status & edge_m)) == $past(rd_status & edge_m)));

    // R5
    p_edge_clear_r5: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        $past(wr_stat_en) |->
        ((rd_status & edge_m & ~$past(wr_data) & ~$past(src_in & ~prev_c)) == '0));

    // R7
    p_aud_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mask[AUD_HI:AUD_LO] == '0) |-> !grp_audio);

    // R8
    p_misc_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status[MISC_HI:MISC_LO] == '0) |-> !grp_misc);

endmodule

bind irq_aggregator irq_aggregator_chk #(
    .NUM_SRC  (NUM_SRC),
    .EDGE_SEL (EDGE_SEL),
    .AUD_LO   (AUD_LO),
    .AUD_HI   (AUD_HI),
    .MISC_LO  (MISC_LO),
    .MISC_HI  (MISC_HI)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_in     (src_in),
    .wr_mask_en (wr_mask_en),
    .wr_stat_en (wr_stat_en),
    .wr_data    (wr_data),
    .rd_status  (rd_status),
    .rd_mask    (rd_mask),
    .grp_audio  (grp_audio),
    .grp_misc   (grp_misc)
);

// File: tb/test_irq_aggregator.sv
`timescale 1ns/1ps
module test_irq_aggregator;

    localparam logic [31:0] EDGES = 32'h1041_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_in = '0;
    logic        wr_mask_en = 1'b0;
    logic        wr_stat_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_status, rd_mask;
    logic        grp_audio, grp_misc, grp_sio;

    int n_run = 0;
    int n_fail = 0;

    logic [31:0] m_stat = '0, m_mask = '0, m_prev = '0;

    always #4 clk = ~clk;

    irq_aggregator i_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .wr_mask_en(wr_mask_en), .wr_stat_en(wr_stat_en), .wr_data(wr_data),
        .rd_status(rd_status), .rd_mask(rd_mask),
        .grp_audio(grp_audio), .grp_misc(grp_misc), .grp_sio(grp_sio)
    );

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        logic [31:0] rise, kill;
        if (!rst_n) begin
            m_stat = '0; m_mask = '0; m_prev = '0;
        end else begin
            rise = src_in & ~m_prev;
            kill = wr_stat_en ? ~wr_data : 32'h0;
            m_stat = (src_in & ~EDGES) | (EDGES & (rise | (m_stat & ~kill)));
            if (wr_mask_en) m_mask = wr_data;
            m_prev = src_in;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R3", rd_status & ~EDGES, m_stat & ~EDGES);
        chk("R4", rd_status & EDGES, m_stat & EDGES);
        chk("R2", rd_mask, m_mask);
        chk("R7", {31'b0, grp_audio}, {31'b0, |(m_stat[7:0] & m_mask[7:0])});
        chk("R8", {31'b0, grp_misc},  {31'b0, |(m_stat[15:8] & m_mask[15:8])});
        chk("R9", {31'b0, grp_sio},   {31'b0, |(m_stat[31:16] & m_mask[31:16])});
    endtask

    task automatic cyc(input logic [31:0] s, input logic wm, input logic ws, input logic [31:0] d);
        @(negedge clk);
        if (rst_n) compare_all();
        src_in = s; wr_mask_en = wm; wr_stat_en = ws; wr_data = d;
    endtask

    task automatic hold();
        cyc(src_in, 1'b0, 1'b0, 32'h0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 status", rd_status, 32'h0);
        chk("R1 mask", rd_mask, 32'h0);
        chk("R1 groups", {29'b0, grp_audio, grp_misc, grp_sio}, 32'h0);
        rst_n = 1'b1;

        // level sources visible with mask zero
        cyc(32'h0000_0081, 0, 0, 0); hold();
        chk("R3 level", rd_status, 32'h0000_0081);
        chk("R10 masked pending", {31'b0, grp_audio}, 32'h0);

        cyc(32'h0000_0081, 1, 0, 32'h0000_0001); hold();
        chk("R2 mask", rd_mask, 32'h0000_0001);
        chk("R7 audio", {31'b0, grp_audio}, 32'h1);

        cyc(32'h0000_0081, 0, 1, 32'h0); hold();
        chk("R3 write ignored", rd_status, 32'h0000_0081);

        // edge capture on 16
        cyc(32'h0001_0081, 0, 0, 0);
        cyc(32'h0000_0081, 0, 0, 0); hold();
        chk("R4 sticky", rd_status & EDGES, 32'h0001_0000);
        cyc(32'h0000_0081, 1, 0, 32'h0001_0000); hold();
        chk("R9 sio", {30'b0, grp_sio, grp_audio}, 32'h2);

        cyc(32'h0000_0081, 0, 1, 32'hFFFF_FFFF); hold();
        chk("R5 one keeps", rd_status & EDGES, 32'h0001_0000);
        cyc(32'h0000_0081, 0, 1, ~32'h0001_0000); hold();
        chk("R5 zero clears", rd_status & EDGES, 32'h0);

        // edge coinciding with clear
        cyc(32'h0040_0081, 0, 1, 32'h0); hold();
        chk("R6 edge wins", rd_status & EDGES, 32'h0040_0000);

        // misc group
        cyc(32'h0000_0200, 1, 1, 32'h0000_0200); hold();
        chk("R8 misc", {31'b0, grp_misc}, 32'h1);

        // held-high edge line does not re-set after acknowledge
        cyc(32'h1000_0000, 0, 0, 0); hold();
        chk("R4 bit28 set", rd_status & EDGES, 32'h1000_0000);
        cyc(32'h1000_0000, 0, 1, 32'h0); hold(); hold();
        chk("R4 level high no re-set", rd_status & EDGES, 32'h0);

        for (int k = 0; k < 3000; k++) begin
            logic [31:0] s;
            s = $urandom;
            cyc(s, ($urandom % 5) == 0, ($urandom % 3) == 0, $urandom);
        end
        hold(); hold();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule